// File: doc/BRIEF.md
# Interrupt Ring Drain Engine

This block is the consumer side of an interrupt vector ring held in memory. A producer writes 16-byte vectors into the ring and keeps its write pointer in a writeback word. On each interrupt pulse the engine samples that word. If the word carries the overflow flag, the engine resynchronises its read pointer past the data that was overwritten. It then fetches each pending vector as four 32-bit words through a synchronous memory read port and decodes the fields.

Vectors whose source id marks a page fault carry a nonzero process address-space id (pasid). For these, the engine asks an external credit port whether to pass them, and drops them if the credit is refused. Every other vector is passed without a query. Decoded entries leave on a valid/ready stream. When the ring is empty the engine publishes the read pointer once, either as a register write or as a writeback-plus-doorbell write, and returns to idle.

Top module: `irq_ring_drain`

## Requirements
- R1: After a synchronous reset, `ent_valid_o`, `mem_rd_en_o`, `credit_req_o`, `ovf_clr_o` and all three publish strobes are low, and `rptr_o` is 0.
- R2: The usable write pointer is the sampled writeback word with its overflow flag (bit 0) cleared, taken modulo the ring size in bytes. Vectors are processed from the read pointer until the read pointer equals this value.
- R3: When bit 0 of the sampled word is set, the read pointer is first set to (usable write pointer + 16) modulo ring size, and `ovf_clr_o` pulses high for exactly one cycle. Otherwise it stays low.
- R4: A vector at byte read pointer P is read as four words at word addresses P/4, P/4+1, P/4+2 and P/4+3, in that order. No entry is presented while reads are in flight.
- R5: Decoded fields are: source id = word0[7:0], data = word1[27:0], ring id = word2[7:0], vmid = word2[15:8], pasid = word2[31:16].
- R6: A vector with source id 146 or 147 and a nonzero pasid raises `credit_req_o` with that pasid, held until `credit_rsp_vld_i`. It is emitted only if `credit_gnt_i` is 1 in that cycle, and is dropped otherwise.
- R7: A vector with any other source id, or with source id 146/147 and pasid 0, is emitted without a credit query.
- R8: The read pointer advances by 16 bytes after every vector, whether emitted or dropped, and wraps modulo the ring size.
- R9: While `ent_valid_o` is high and `ent_ready_i` is low, `ent_valid_o` and all entry fields hold their values.
- R10: Each drain ends with exactly one publish of the final read pointer on `rptr_o`. With `doorbell_mode_i` = 0 only `rptr_reg_we_o` pulses. With `doorbell_mode_i` = 1, `rptr_wb_we_o` and `doorbell_we_o` pulse together and `rptr_reg_we_o` stays low.
- R11: An interrupt pulse that arrives while a drain is in progress causes one further drain after the current publish.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pulse_i | input | 1 | Interrupt pulse that starts a drain |
| wb_wptr_i | input | PTR_W | Writeback word: byte write pointer, bit 0 = overflow flag |
| doorbell_mode_i | input | 1 | Publish via writeback and doorbell when 1, via register when 0 |
| mem_rd_en_o | output | 1 | Ring memory read enable |
| mem_rd_addr_o | output | PTR_W-2 | Ring memory word address |
| mem_rd_data_i | input | 32 | Read data, valid one cycle after the enable |
| credit_req_o | output | 1 | Credit query for a fault vector |
| credit_pasid_o | output | 16 | Pasid under query |
| credit_rsp_vld_i | input | 1 | Credit response valid |
| credit_gnt_i | input | 1 | Credit granted |
| ent_valid_o | output | 1 | Decoded entry valid |
| ent_ready_i | input | 1 | Downstream accepts entry |
| ent_src_o | output | 8 | Source id |
| ent_data_o | output | 28 | Source data |
| ent_ring_o | output | 8 | Ring id |
| ent_vmid_o | output | 8 | VM id |
| ent_pasid_o | output | 16 | Pasid |
| rptr_o | output | PTR_W | Published read pointer |
| rptr_reg_we_o | output | 1 | Register publish strobe |
| rptr_wb_we_o | output | 1 | Writeback publish strobe |
| doorbell_we_o | output | 1 | Doorbell publish strobe |
| ovf_clr_o | output | 1 | Overflow-clear pulse toward the producer |

## Verification
A corrupted read pointer shows up on the first emitted entry after it: the decoded fields come from the wrong slot. It also shows up in the published pointer at the end of the same drain. A wrong overflow offset or wrong wrap changes the number of entries in that drain. A broken prescreen shows as a mismatch between credit queries and emitted entries within one vector time, about ten cycles. The bench compares every entry of every drain against a model of the ring, so any such error surfaces at the latest at the next publish.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
  localparam int unsigned VEC_BYTES   = 16;
  localparam logic [7:0]  FAULT_SRC_A = 8'd146;
  localparam logic [7:0]  FAULT_SRC_B = 8'd147;

  typedef struct packed {
    logic [15:0] pasid;
    logic [7:0]  vmid;
    logic [7:0]  ring;
    logic [27:0] data;
    logic [7:0]  src;
  } irqr_entry_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SAMPLE, ST_CMP, ST_FETCH, ST_CHECK,
    ST_CREDIT, ST_EMIT, ST_ADV, ST_PUB
  } irqr_state_e;
endpackage

// File: rtl/irqr_ptr_calc.sv
module irqr_ptr_calc
  import irqr_pkg::*;
#(
  parameter int PTR_W   = 10,
  parameter int OVF_BIT = 0
) (
  input  logic [PTR_W-1:0] raw_i,
  output logic             ovf_o,
  output logic [PTR_W-1:0] wptr_o,
  output logic [PTR_W-1:0] resync_o
);
  always_comb begin
    ovf_o           = raw_i[OVF_BIT];
    wptr_o          = raw_i;
    wptr_o[OVF_BIT] = 1'b0;
    resync_o        = wptr_o + PTR_W'(VEC_BYTES);
  end
endmodule

// File: rtl/irqr_vec_dec.sv
module irqr_vec_dec
  import irqr_pkg::*;
(
  input  logic [7:0]  src_i,
  input  logic [27:0] data_i,
  input  logic [31:0] w2_i,
  output irqr_entry_t ent_o,
  output logic        need_credit_o
);
  always_comb begin
    ent_o.src     = src_i;
    ent_o.data    = data_i;
    ent_o.ring    = w2_i[7:0];
    ent_o.vmid    = w2_i[15:8];
    ent_o.pasid   = w2_i[31:16];
    need_credit_o = ((src_i == FAULT_SRC_A) || (src_i == FAULT_SRC_B)) &&
                    (w2_i[31:16] != 16'd0);
  end
endmodule

// File: rtl/irq_ring_drain.sv
module irq_ring_drain
  import irqr_pkg::*;
#(
  parameter int RING_BYTES = 1024,
  parameter int OVF_BIT    = 0,
  localparam int PTR_W     = $clog2(RING_BYTES),
  localparam int WIDX_W    = PTR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_pulse_i,
  input  logic [PTR_W-1:0]  wb_wptr_i,
  input  logic              doorbell_mode_i,
  output logic              mem_rd_en_o,
  output logic [WIDX_W-1:0] mem_rd_addr_o,
  input  logic [31:0]       mem_rd_data_i,
  output logic              credit_req_o,
  output logic [15:0]       credit_pasid_o,
  input  logic              credit_rsp_vld_i,
  input  logic              credit_gnt_i,
  output logic              ent_valid_o,
  input  logic              ent_ready_i,
  output logic [7:0]        ent_src_o,
  output logic [27:0]       ent_data_o,
  output logic [7:0]        ent_ring_o,
  output logic [7:0]        ent_vmid_o,
  output logic [15:0]       ent_pasid_o,
  output logic [PTR_W-1:0]  rptr_o,
  output logic              rptr_reg_we_o,
  output logic              rptr_wb_we_o,
  output logic              doorbell_we_o,
  output logic              ovf_clr_o
);
  irqr_state_e       state;
  logic [PTR_W-1:0]  rptr_q, wptr_q, pub_q;
  logic              pend_q, ovf_clr_q;
  logic              en_q, vld_q;
  logic [WIDX_W-1:0] addr_q;
  logic [2:0]        iss_cnt;
  logic [1:0]        cap_cnt;
  logic [7:0]        src_q;
  logic [27:0]       dat_q;
  logic [31:0]       w2_q;
  irqr_entry_t       ent_q, dec;
  logic              ent_vld_q, creq_q;
  logic [15:0]       cpasid_q;
  logic              reg_we_q, wb_we_q, db_we_q;
  logic              ovf_c, need_credit;
  logic [PTR_W-1:0]  wptr_c, resync_c;
  logic [WIDX_W-1:0] base_idx;

  assign base_idx = rptr_q[PTR_W-1:2];

  irqr_ptr_calc #(.PTR_W(PTR_W), .OVF_BIT(OVF_BIT)) u_ptr (
    .raw_i(wb_wptr_i), .ovf_o(ovf_c), .wptr_o(wptr_c), .resync_o(resync_c)
  );

  irqr_vec_dec u_dec (
    .src_i(src_q), .data_i(dat_q), .w2_i(w2_q),
    .ent_o(dec), .need_credit_o(need_credit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      rptr_q    <= '0;
      wptr_q    <= '0;
      pub_q     <= '0;
      pend_q    <= 1'b0;
      ovf_clr_q <= 1'b0;
      en_q      <= 1'b0;
      vld_q     <= 1'b0;
      addr_q    <= '0;
      iss_cnt   <= '0;
      cap_cnt   <= '0;
      src_q     <= '0;
      dat_q     <= '0;
      w2_q      <= '0;
      ent_q     <= '0;
      ent_vld_q <= 1'b0;
      creq_q    <= 1'b0;
      cpasid_q  <= '0;
      reg_we_q  <= 1'b0;
      wb_we_q   <= 1'b0;
      db_we_q   <= 1'b0;
    end else begin
      ovf_clr_q <= 1'b0;
      reg_we_q  <= 1'b0;
      wb_we_q   <= 1'b0;
      db_we_q   <= 1'b0;
      vld_q     <= en_q;
      if (irq_pulse_i && state != ST_IDLE) pend_q <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (irq_pulse_i || pend_q) begin
            pend_q <= 1'b0;
            state  <= ST_SAMPLE;
          end
        end
        ST_SAMPLE: begin
          wptr_q <= wptr_c;
          if (ovf_c) begin
            rptr_q    <= resync_c;
            ovf_clr_q <= 1'b1;
          end
          state <= ST_CMP;
        end
        ST_CMP: begin
          if (rptr_q == wptr_q) begin
            state <= ST_PUB;
          end else begin
            iss_cnt <= '0;
            cap_cnt <= '0;
            state   <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (iss_cnt < 3'd4) begin
            en_q    <= 1'b1;
            addr_q  <= base_idx + WIDX_W'(iss_cnt);
            iss_cnt <= iss_cnt + 3'd1;
          end else begin
            en_q <= 1'b0;
          end
          if (vld_q) begin
            case (cap_cnt)
              2'd0:    src_q <= mem_rd_data_i[7:0];
              2'd1:    dat_q <= mem_rd_data_i[27:0];
              2'd2:    w2_q  <= mem_rd_data_i;
              default: ;
            endcase
            cap_cnt <= cap_cnt + 2'd1;
            if (cap_cnt == 2'd3) state <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          ent_q    <= dec;
          cpasid_q <= dec.pasid;
          if (need_credit) begin
            creq_q <= 1'b1;
            state  <= ST_CREDIT;
          end else begin
            ent_vld_q <= 1'b1;
            state     <= ST_EMIT;
          end
        end
        ST_CREDIT: begin
          if (credit_rsp_vld_i) begin
            creq_q <= 1'b0;
            if (credit_gnt_i) begin
              ent_vld_q <= 1'b1;
              state     <= ST_EMIT;
            end else begin
              state <= ST_ADV;
            end
          end
        end
        ST_EMIT: begin
          if (ent_ready_i) begin
            ent_vld_q <= 1'b0;
            state     <= ST_ADV;
          end
        end
        ST_ADV: begin
          rptr_q <= rptr_q + PTR_W'(VEC_BYTES);
          state  <= ST_CMP;
        end
        ST_PUB: begin
          pub_q <= rptr_q;
          if (doorbell_mode_i) begin
            wb_we_q <= 1'b1;
            db_we_q <= 1'b1;
          end else begin
            reg_we_q <= 1'b1;
          end
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_rd_en_o    = en_q;
  assign mem_rd_addr_o  = addr_q;
  assign credit_req_o   = creq_q;
  assign credit_pasid_o = cpasid_q;
  assign ent_valid_o    = ent_vld_q;
  assign ent_src_o      = ent_q.src;
  assign ent_data_o     = ent_q.data;
  assign ent_ring_o     = ent_q.ring;
  assign ent_vmid_o     = ent_q.vmid;
  assign ent_pasid_o    = ent_q.pasid;
  assign rptr_o         = pub_q;
  assign rptr_reg_we_o  = reg_we_q;
  assign rptr_wb_we_o   = wb_we_q;
  assign doorbell_we_o  = db_we_q;
  assign ovf_clr_o      = ovf_clr_q;
endmodule

// File: rtl/irqr_checker.sv
module irqr_checker (
  input logic        clk,
  input logic        rst,
  input logic        mem_rd_en_o,
  input logic        credit_req_o,
  input logic [15:0] credit_pasid_o,
  input logic        credit_rsp_vld_i,
  input logic        ent_valid_o,
  input logic        ent_ready_i,
  input logic [7:0]  ent_src_o,
  input logic [27:0] ent_data_o,
  input logic [15:0] ent_pasid_o,
  input logic        rptr_reg_we_o,
  input logic        rptr_wb_we_o,
  input logic        doorbell_we_o,
  input logic        ovf_clr_o
);
  AST_OVF_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ovf_clr_o |=> !ovf_clr_o); // R3

  AST_NO_EMIT_DURING_READ: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en_o |-> !ent_valid_o); // R4

  AST_CREDIT_PASID_NZ: assert property (@(posedge clk) disable iff (rst)
    credit_req_o |-> (credit_pasid_o != 16'd0)); // R6

  AST_CREDIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (credit_req_o && !credit_rsp_vld_i) |=> (credit_req_o && $stable(credit_pasid_o))); // R6

  AST_NO_EMIT_WHILE_QUERY: assert property (@(posedge clk) disable iff (rst)
    !(credit_req_o && ent_valid_o)); // R6

  AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (ent_valid_o && !ent_ready_i) |=>
      (ent_valid_o && $stable(ent_src_o) && $stable(ent_data_o) && $stable(ent_pasid_o))); // R9

  AST_PUB_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(rptr_reg_we_o && (rptr_wb_we_o || doorbell_we_o))); // R10

  AST_PUB_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (rptr_reg_we_o || doorbell_we_o) |=> !(rptr_reg_we_o || doorbell_we_o)); // R10
endmodule

bind irq_ring_drain irqr_checker u_irqr_chk (
  .clk(clk), .rst(rst), .mem_rd_en_o(mem_rd_en_o),
  .credit_req_o(credit_req_o), .credit_pasid_o(credit_pasid_o),
  .credit_rsp_vld_i(credit_rsp_vld_i), .ent_valid_o(ent_valid_o),
  .ent_ready_i(ent_ready_i), .ent_src_o(ent_src_o), .ent_data_o(ent_data_o),
  .ent_pasid_o(ent_pasid_o), .rptr_reg_we_o(rptr_reg_we_o),
  .rptr_wb_we_o(rptr_wb_we_o), .doorbell_we_o(doorbell_we_o),
  .ovf_clr_o(ovf_clr_o)
);

// File: tb/irq_ring_drain_tb_top.sv
module irq_ring_drain_tb_top;
  localparam int RING_BYTES = 1024;
  localparam int PTR_W  = 10;
  localparam int WIDX_W = 8;
  localparam int NWORDS = 256;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              irq_pulse_i = 1'b0;
  logic [PTR_W-1:0]  wb_wptr_i = '0;
  logic              doorbell_mode_i = 1'b0;
  logic              mem_rd_en_o;
  logic [WIDX_W-1:0] mem_rd_addr_o;
  logic [31:0]       mem_rd_data_i = '0;
  logic              credit_req_o;
  logic [15:0]       credit_pasid_o;
  logic              credit_rsp_vld_i = 1'b0;
  logic              credit_gnt_i = 1'b0;
  logic              ent_valid_o;
  logic              ent_ready_i = 1'b1;
  logic [7:0]        ent_src_o;
  logic [27:0]       ent_data_o;
  logic [7:0]        ent_ring_o;
  logic [7:0]        ent_vmid_o;
  logic [15:0]       ent_pasid_o;
  logic [PTR_W-1:0]  rptr_o;
  logic              rptr_reg_we_o, rptr_wb_we_o, doorbell_we_o, ovf_clr_o;

  always #4 clk = ~clk;

  irq_ring_drain #(.RING_BYTES(RING_BYTES)) dut_i (.*);

  logic [31:0] mem [NWORDS];
  always @(posedge clk) if (mem_rd_en_o) mem_rd_data_i <= mem[mem_rd_addr_o];

  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit stall = 1'b0;
  int credit_cnt = 0, pub_cnt = 0, ovf_cnt = 0, got_n = 0;
  logic [PTR_W-1:0] last_pub;
  bit last_reg, last_wb, last_db;
  logic [67:0] got_e [128];
  logic [67:0] exp_e [128];
  logic [PTR_W-1:0] m_rptr = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // credit responder: grant iff pasid is odd
  initial begin
    forever begin
      @(negedge clk);
      if (credit_req_o) begin
        repeat (2) @(negedge clk);
        credit_gnt_i     = credit_pasid_o[0];
        credit_rsp_vld_i = 1'b1;
        @(negedge clk);
        credit_rsp_vld_i = 1'b0;
        credit_cnt++;
      end
    end
  end

  // output sink and port monitors
  always @(negedge clk) begin
    ent_ready_i = stall ? ~ent_ready_i : 1'b1;
    if (ent_valid_o && ent_ready_i && got_n < 128) begin
      got_e[got_n] = {ent_pasid_o, ent_vmid_o, ent_ring_o, ent_data_o, ent_src_o};
      got_n++;
    end
    if (rptr_reg_we_o || doorbell_we_o || rptr_wb_we_o) begin
      pub_cnt++;
      last_pub = rptr_o;
      last_reg = rptr_reg_we_o;
      last_wb  = rptr_wb_we_o;
      last_db  = doorbell_we_o;
    end
    if (ovf_clr_o) ovf_cnt++;
  end

  task automatic set_vec(input int slot, input logic [7:0] src, input logic [15:0] pasid);
    mem[slot*4]     = {24'h5A5A00, src};
    mem[slot*4 + 2] = {pasid, 8'(slot + 'h40), 8'(slot + 'h80)};
  endtask

  task automatic pulse();
    @(negedge clk);
    irq_pulse_i = 1'b1;
    @(negedge clk);
    irq_pulse_i = 1'b0;
  endtask

  // builds expected entries and query count from the ring image
  task automatic model(input logic [PTR_W-1:0] wb, output int n, output int q);
    logic [PTR_W-1:0] w;
    w = wb & ~PTR_W'(1);
    if (wb[0]) m_rptr = w + PTR_W'(16);
    n = 0;
    q = 0;
    while (m_rptr != w) begin
      int idx;
      logic [7:0] s;
      logic [15:0] p;
      bit f;
      idx = int'(m_rptr) / 4;
      s = mem[idx][7:0];
      p = mem[idx+2][31:16];
      f = (s == 8'd146 || s == 8'd147) && p != 16'd0;
      if (f) q++;
      if (!f || p[0]) begin
        exp_e[n] = {p, mem[idx+2][15:8], mem[idx+2][7:0], mem[idx+1][27:0], s};
        n++;
      end
      m_rptr = m_rptr + PTR_W'(16);
    end
  endtask

  task automatic wait_pubs(input int target, input string tag);
    int t = 0;
    while (pub_cnt < target && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk(pub_cnt >= target, "R10", {tag, " publish seen"}, pub_cnt, target);
    repeat (4) @(negedge clk);
  endtask

  task automatic check_drain(input string tag, input int n, input int q, input int c0,
                             input int o0, input bit ovf, input logic [PTR_W-1:0] w,
                             input bit db);
    chk(got_n == n, "R2", {tag, " entry count"}, got_n, n);
    for (int i = 0; i < n && i < got_n; i++)
      chk(got_e[i] == exp_e[i], "R5", {tag, " entry fields"}, got_e[i], exp_e[i]);
    chk(credit_cnt - c0 == q, "R6", {tag, " credit queries"}, credit_cnt - c0, q);
    chk(ovf_cnt - o0 == int'(ovf), "R3", {tag, " overflow-clear pulses"}, ovf_cnt - o0, ovf);
    chk(last_pub == w, "R8", {tag, " published pointer"}, last_pub, w);
    chk({last_reg, last_wb, last_db} == (db ? 3'b011 : 3'b100), "R10",
        {tag, " publish path"}, {last_reg, last_wb, last_db}, db ? 3'b011 : 3'b100);
  endtask

  task automatic run_drain(input logic [PTR_W-1:0] wb, input bit db, input string tag);
    int n, q, c0, o0, p0;
    model(wb, n, q);
    c0 = credit_cnt; o0 = ovf_cnt; p0 = pub_cnt; got_n = 0;
    doorbell_mode_i = db;
    wb_wptr_i = wb;
    pulse();
    wait_pubs(p0 + 1, tag);
    chk(pub_cnt == p0 + 1, "R10", {tag, " single publish"}, pub_cnt, p0 + 1);
    check_drain(tag, n, q, c0, o0, wb[0], wb & ~PTR_W'(1), db);
  endtask

  task automatic t_reset();
    chk(!ent_valid_o && !mem_rd_en_o && !credit_req_o && !ovf_clr_o, "R1",
        "reset strobes", {ent_valid_o, mem_rd_en_o, credit_req_o, ovf_clr_o}, 0);
    chk(!rptr_reg_we_o && !rptr_wb_we_o && !doorbell_we_o, "R1", "reset publish",
        {rptr_reg_we_o, rptr_wb_we_o, doorbell_we_o}, 0);
    chk(rptr_o == '0, "R1", "reset pointer", rptr_o, 0);
  endtask

  // R2 R4 R5 basic register-mode drain
  task automatic t_basic();
    run_drain(10'h020, 1'b0, "basic");
  endtask

  // R6 R7 fault prescreen: deny, pasid zero, grant, deny
  task automatic t_fault();
    set_vec(2, 8'd146, 16'h0006);
    set_vec(3, 8'd147, 16'h0000);
    set_vec(4, 8'd146, 16'h0009);
    set_vec(5, 8'd147, 16'h0010);
    run_drain(10'h060, 1'b0, "fault");
  endtask

  // R9 back-pressure on the entry stream
  task automatic t_stall();
    stall = 1'b1;
    run_drain(10'h0A0, 1'b0, "stall");
    stall = 1'b0;
  endtask

  // R2 empty ring still publishes once
  task automatic t_empty();
    run_drain(10'h0A0, 1'b0, "empty");
  endtask

  // R10 doorbell publish path
  task automatic t_doorbell();
    run_drain(10'h0C0, 1'b1, "doorbell");
  endtask

  // R3 overflow resync then drain around the ring
  task automatic t_overflow();
    run_drain(10'h3F1, 1'b0, "overflow");
  endtask

  // R8 read pointer wraps past the ring end
  task automatic t_wrap();
    run_drain(10'h020, 1'b0, "wrap");
  endtask

  // R11 pulse during a drain triggers another drain
  task automatic t_pending();
    int n, q, c0, o0, p0;
    model(10'h100, n, q);
    c0 = credit_cnt; o0 = ovf_cnt; p0 = pub_cnt; got_n = 0;
    doorbell_mode_i = 1'b0;
    wb_wptr_i = 10'h060;
    pulse();
    repeat (3) @(negedge clk);
    wb_wptr_i = 10'h100;
    pulse();
    wait_pubs(p0 + 2, "pending");
    chk(pub_cnt == p0 + 2, "R11", "pending second drain publishes", pub_cnt, p0 + 2);
    check_drain("pending", n, q, c0, o0, 1'b0, 10'h100, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < NWORDS; i++) begin
      case (i % 4)
        0: mem[i] = {24'h5A5A00, 8'(i / 4)};
        1: mem[i] = {4'hF, 28'((i / 4) * 32'h0123457)};
        2: mem[i] = {16'((i / 4) * 16'h0101 + 16'd2), 8'(i / 4 + 'h40), 8'(i / 4 + 'h80)};
        default: mem[i] = 32'hDEAD0000 | 32'(i);
      endcase
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_fault();
    t_stall();
    t_empty();
    t_doorbell();
    t_overflow();
    t_wrap();
    t_pending();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule